// File: doc/BRIEF.md
# Boot Image Load Checker

This block sits next to a byte-stream loader that copies a program image into memory. Each byte the loader delivers is accepted, written to memory at its position in the image, and added to a running 8-bit checksum. The first sixteen bytes are also held as a header. Once the header is complete, its program-length field takes over the count of bytes still expected. This means a request longer than the real image is cut short by the image itself.

When the stream ends, the block checks two things: the checksum and whether a transfer error was flagged. For a good image, it then runs a short word-write sequence. This sequence puts a stack marker word at each of the two words just below the stack base, and zeroes every word between the end of the program and the lower marker. A no-store mode runs the checksum and header capture but issues no memory writes. Done, valid and error outputs report the outcome.

Top module: `boot_load_checker`

## Requirements
- R1: The checksum starts at 0xEC and adds every accepted byte modulo 256. The image is valid only when the final sum is 0x00 and no transfer error was seen. At the end, `done_o` pulses for one cycle, and exactly one of `valid_o` / `err_o` is then held until the next accepted start.
- R2: Image byte k (k = 0..15) is held in `header_o[8k+7:8k]`, so each 32-bit header word is little-endian.
- R3: `remaining_o` loads `len_i` on start and decreases by one per accepted byte. When byte 15 is accepted, it is replaced by the 16-bit length field (image byte 8 low, byte 9 high) minus 16, saturating at 0. The load ends when it reaches 0.
- R4: A start with `len_i` below 16 is refused. On the next cycle `done_o` and `err_o` are 1, `busy_o` is 0, and nothing is written.
- R5: During the load, byte k is written at address LOAD_BASE+k. The byte enable is one-hot at address bits [1:0], and the byte is replicated on all four lanes of `mem_wdata_o`.
- R6: After a valid load, 0xFFF9FFFF is written as a full word at stack base − 8 and at stack base − 4. The stack base is the 16-bit field at image bytes 10 (low) and 11 (high), assumed word-aligned and at least 8.
- R7: After the markers, every word from the program end rounded up to a multiple of 4, up to but not including stack base − 8, is written with zero. Program bytes below that rounded-up end are untouched.
- R8: An invalid image sets `err_o` and issues no marker or clearing writes.
- R9: With no-store selected at start, `mem_we_o` stays 0 for the whole load and finish. The header and checksum still behave as in R1 and R2.
- R10: A transfer error flagged in any cycle of the load makes the image invalid.
- R11: Bytes presented while no load is running are ignored. They cause no write, and `remaining_o` and the status outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, sampled while idle |
| len_i | input | 16 | Requested byte count |
| no_store_i | input | 1 | Suppress all memory writes for this load |
| byte_valid_i | input | 1 | Stream byte present |
| byte_i | input | 8 | Stream byte |
| xfer_err_i | input | 1 | Transfer error from the loader |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| remaining_o | output | 16 | Bytes still expected |
| header_o | output | 128 | Captured first 16 bytes |
| busy_o | output | 1 | Load or finish in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Last load was a good image |
| err_o | output | 1 | Last load was refused or bad |

## Verification
The bench covers these corner cases, and what a wrong design would do in each:

- **Header length shorter than the request.** A design that ignored the header would keep consuming bytes and hang.
- **Length field below 16.** A design without saturation would wrap the count and stall.
- **Program end not word-aligned.** Rounding down would zero the last program bytes.
- **Clearing overlapping the header area.** A design that treats this as a special case would leave wrong bytes in the first words.
- **Checksum off by one, and a transfer error mid-stream.** Either must show up as an error with no marker or clearing writes.
- **No-store loads.** Any write leaking through shows as a changed memory byte.
- **Refused requests of 15 bytes.** Must raise the error without starting a load.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam int unsigned HDR_BYTES  = 16;
  localparam int unsigned LEN_OFS    = 8;
  localparam int unsigned SBASE_OFS  = 10;
  localparam logic [7:0]  CSUM_SEED  = 8'hEC;
  localparam logic [31:0] STACK_MARK = 32'hFFF9_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CHECK, ST_POST} ld_state_e;
  typedef enum logic [1:0] {PS_IDLE, PS_MARK_LO, PS_MARK_HI, PS_CLEAR} post_state_e;
endpackage

// File: rtl/bil_hdr_capture.sv
module bil_hdr_capture #(
  parameter int unsigned NB = 16,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [7:0]      byte_i,
  output logic [8*NB-1:0] hdr_o
);
  logic [8*NB-1:0] hdr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hdr_q <= '0;
    else if (clr_i) hdr_q <= '0;
    else if (wr_i)  hdr_q[8*idx_i +: 8] <= byte_i;
  end

  assign hdr_o = hdr_q;
endmodule

// File: rtl/bil_csum.sv
module bil_csum #(
  parameter logic [7:0] SEED = 8'hEC
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] sum_o
);
  logic [7:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= SEED;
    else if (clr_i) sum_q <= SEED;
    else if (add_i) sum_q <= sum_q + byte_i;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/bil_post_seq.sv
module bil_post_seq
  import bil_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] prog_end_i,
  input  logic [ADDR_W-1:0] stack_base_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  output logic              done_o
);
  localparam int unsigned XW = ADDR_W + 1;

  post_state_e   ps_q;
  logic [XW-1:0] cur_q;
  logic          done_q;
  logic [XW-1:0] end_al, mark_lo, cur_nx;
  logic          clr_en;

  // extra top bit keeps the range compare free of wrap
  always_comb begin
    end_al  = ({1'b0, prog_end_i} + XW'(3)) & ~XW'(3);
    mark_lo = {1'b0, stack_base_i} - XW'(8);
    clr_en  = (stack_base_i >= ADDR_W'(8)) && (end_al < mark_lo);
    cur_nx  = cur_q + XW'(4);
  end

  always_comb begin
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (ps_q)
      PS_MARK_LO: begin
        we_o    = 1'b1;
        addr_o  = mark_lo[ADDR_W-1:0];
        wdata_o = STACK_MARK;
      end
      PS_MARK_HI: begin
        we_o    = 1'b1;
        addr_o  = stack_base_i - ADDR_W'(4);
        wdata_o = STACK_MARK;
      end
      PS_CLEAR: begin
        we_o    = 1'b1;
        addr_o  = cur_q[ADDR_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= PS_IDLE;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ps_q)
        PS_IDLE:    if (go_i) ps_q <= PS_MARK_LO;
        PS_MARK_LO: ps_q <= PS_MARK_HI;
        PS_MARK_HI: begin
          if (clr_en) begin
            cur_q <= end_al;
            ps_q  <= PS_CLEAR;
          end else begin
            done_q <= 1'b1;
            ps_q   <= PS_IDLE;
          end
        end
        PS_CLEAR: begin
          if (cur_nx >= mark_lo) begin
            done_q <= 1'b1;
            ps_q   <= PS_IDLE;
          end else begin
            cur_q <= cur_nx;
          end
        end
        default: ps_q <= PS_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/boot_load_checker.sv
module boot_load_checker
  import bil_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOAD_BASE = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [15:0]             len_i,
  input  logic                    no_store_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic                    xfer_err_i,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [3:0]              mem_be_o,
  output logic [31:0]             mem_wdata_o,
  output logic [15:0]             remaining_o,
  output logic [8*HDR_BYTES-1:0]  header_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    valid_o,
  output logic                    err_o
);
  localparam int unsigned HIW = $clog2(HDR_BYTES);

  ld_state_e         st_q;
  logic [15:0]       rem_q, rem_nxt;
  logic [ADDR_W-1:0] idx_q;
  logic              no_store_q, xerr_q, done_q, valid_q, err_q;
  logic              accept, hdr_wr, last_hdr, clr, good, post_go;
  logic [7:0]        sum;
  logic [15:0]       len_fld, sb_fld;
  logic [ADDR_W-1:0] prog_end, load_addr;
  logic              post_we, post_done;
  logic [ADDR_W-1:0] post_addr;
  logic [31:0]       post_wdata;

  assign accept   = (st_q == ST_LOAD) && byte_valid_i;
  assign hdr_wr   = accept && (idx_q < ADDR_W'(HDR_BYTES));
  assign last_hdr = accept && (idx_q == ADDR_W'(HDR_BYTES - 1));
  assign clr      = (st_q == ST_IDLE) && start_i;
  assign good     = (sum == 8'h00) && !xerr_q;
  assign post_go  = (st_q == ST_CHECK) && good && !no_store_q;

  bil_hdr_capture #(.NB(HDR_BYTES)) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .wr_i   (hdr_wr),
    .idx_i  (idx_q[HIW-1:0]),
    .byte_i (byte_i),
    .hdr_o  (header_o)
  );

  bil_csum #(.SEED(CSUM_SEED)) u_csum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .add_i  (accept),
    .byte_i (byte_i),
    .sum_o  (sum)
  );

  assign len_fld   = header_o[8*LEN_OFS +: 16];
  assign sb_fld    = header_o[8*SBASE_OFS +: 16];
  assign prog_end  = ADDR_W'(LOAD_BASE) + ADDR_W'(len_fld);
  assign load_addr = ADDR_W'(LOAD_BASE) + idx_q;

  bil_post_seq #(.ADDR_W(ADDR_W)) u_post (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (post_go),
    .prog_end_i   (prog_end),
    .stack_base_i (ADDR_W'(sb_fld)),
    .we_o         (post_we),
    .addr_o       (post_addr),
    .wdata_o      (post_wdata),
    .done_o       (post_done)
  );

  // header length overrides the requested count once byte 15 lands
  always_comb begin
    if (last_hdr)
      rem_nxt = (len_fld > 16'(HDR_BYTES)) ? len_fld - 16'(HDR_BYTES) : 16'd0;
    else
      rem_nxt = rem_q - 16'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      idx_q      <= '0;
      no_store_q <= 1'b0;
      xerr_q     <= 1'b0;
      done_q     <= 1'b0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            valid_q    <= 1'b0;
            err_q      <= 1'b0;
            xerr_q     <= 1'b0;
            no_store_q <= no_store_i;
            idx_q      <= '0;
            if (len_i < 16'(HDR_BYTES)) begin
              rem_q  <= '0;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              rem_q <= len_i;
              st_q  <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (xfer_err_i) xerr_q <= 1'b1;
          if (accept) begin
            rem_q <= rem_nxt;
            idx_q <= idx_q + ADDR_W'(1);
            if (rem_nxt == 16'd0) st_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (!good) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (no_store_q) begin
            valid_q <= 1'b1;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_POST;
          end
        end
        ST_POST: begin
          if (post_done) begin
            valid_q <= 1'b1;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (st_q == ST_LOAD) begin
      mem_we_o    = accept && !no_store_q;
      mem_addr_o  = load_addr;
      mem_be_o    = 4'b0001 << load_addr[1:0];
      mem_wdata_o = {4{byte_i}};
    end else begin
      mem_we_o    = post_we && !no_store_q;
      mem_addr_o  = post_addr;
      mem_be_o    = 4'hF;
      mem_wdata_o = post_wdata;
    end
  end

  assign remaining_o = rem_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign valid_o     = valid_q;
  assign err_o       = err_q;
endmodule

// File: rtl/bil_chk.sv
module bil_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [15:0] len_i,
  input logic        busy_i,
  input logic        done_i,
  input logic        valid_i,
  input logic        err_i,
  input logic        mem_we_i,
  input logic [3:0]  mem_be_i,
  input logic        accept_i,
  input logic        last_hdr_i,
  input logic        no_store_i,
  input logic [15:0] remaining_i
);
  // R4
  short_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && len_i < 16'd16) |=> (done_i && err_i && !busy_i && !mem_we_i));

  // R1
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (valid_i != err_i));

  // R8
  invalid_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !busy_i) |-> !mem_we_i);

  // R3
  rem_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !last_hdr_i && remaining_i > 16'd1) |=> (remaining_i == $past(remaining_i) - 16'd1));

  // R5
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && mem_we_i) |-> ($countones(mem_be_i) == 1));

  // R9
  no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && no_store_i) |-> !mem_we_i);
endmodule

bind boot_load_checker bil_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .len_i       (len_i),
  .busy_i      (busy_o),
  .done_i      (done_o),
  .valid_i     (valid_o),
  .err_i       (err_o),
  .mem_we_i    (mem_we_o),
  .mem_be_i    (mem_be_o),
  .accept_i    (accept),
  .last_hdr_i  (last_hdr),
  .no_store_i  (no_store_q),
  .remaining_i (remaining_o)
);

// File: tb/sim_boot_load_checker.sv
module sim_boot_load_checker;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_ni, start_i, no_store_i, byte_valid_i, xfer_err_i;
  logic [15:0]  len_i;
  logic [7:0]   byte_i;
  logic         mem_we_o, busy_o, done_o, valid_o, err_o;
  logic [15:0]  mem_addr_o, remaining_o;
  logic [3:0]   mem_be_o;
  logic [31:0]  mem_wdata_o;
  logic [127:0] header_o;

  boot_load_checker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
    .no_store_i(no_store_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .xfer_err_i(xfer_err_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .remaining_o(remaining_o),
    .header_o(header_o), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0, wr_cnt = 0, cyc = 0, n_img = 0;
  logic [7:0] mem [1024];
  logic [7:0] img [256];

  always @(posedge clk) begin
    if (mem_we_o) begin
      wr_cnt++;
      for (int b = 0; b < 4; b++) begin
        int a;
        a = (int'(mem_addr_o) & ~3) + b;
        if (mem_be_o[b] && a < 1024) mem[a] = mem_wdata_o[8*b +: 8];
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: got hang exp done");
      finish_run();
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_aa();
    for (int i = 0; i < 1024; i++) mem[i] = 8'hAA;
  endtask

  task automatic build(int L, int sb, bit good);
    logic [7:0] s;
    n_img = (L > 16) ? L : 16;
    for (int i = 0; i < n_img; i++) img[i] = 8'(i * 7 + 3);
    img[8] = 8'(L); img[9] = 8'(L >> 8); img[10] = 8'(sb); img[11] = 8'(sb >> 8);
    s = 8'hEC;
    for (int i = 0; i < n_img - 1; i++) s = s + img[i];
    img[n_img-1] = 8'h00 - s + (good ? 8'h00 : 8'h01);
  endtask

  // exp16 < 0 skips the post-header count check
  task automatic run_load(int len_req, bit ns, int err_at, int exp16);
    bit got;
    @(negedge clk);
    start_i = 1'b1; len_i = 16'(len_req); no_store_i = ns;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n_img; i++) begin
      if (i % 5 == 4) begin byte_valid_i = 1'b0; xfer_err_i = 1'b0; @(negedge clk); end
      if (i == 16 && exp16 >= 0) chk("R3", "count after header", 64'(remaining_o), 64'(exp16));
      byte_valid_i = 1'b1; byte_i = img[i]; xfer_err_i = (i == err_at);
      @(negedge clk);
    end
    byte_valid_i = 1'b0; xfer_err_i = 1'b0;
    chk("R3", "count at stream end", 64'(remaining_o), 64'd0);
    got = 1'b0;
    for (int k = 0; k < 4000 && !got; k++) begin
      if (done_o) got = 1'b1;
      else @(negedge clk);
    end
    chk("R1", "done pulse seen", 64'(got), 64'd1);
  endtask

  task automatic check_mem(string req, int L, int sb, bit stored, bit post);
    int endal, mlo, bad, fa;
    logic [7:0] e, fe, fg;
    endal = (L + 3) & ~3; mlo = sb - 8; bad = 0; fa = 0; fe = 0; fg = 0;
    for (int a = 0; a < 256; a++) begin
      e = 8'hAA;
      if (stored && a < n_img) e = img[a];
      if (post) begin
        if (a >= mlo && a < sb) e = ((a - mlo) % 4 == 2) ? 8'hF9 : 8'hFF;
        else if (a >= endal && a < mlo) e = 8'h00;
      end
      if (mem[a] !== e && bad == 0) begin bad = 1; fa = a; fe = e; fg = mem[a]; end
    end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s memory byte %0d: got %0h exp %0h", req, fa, fg, fe);
    end
  endtask

  task automatic t_reset();
    chk("R1", "reset busy", 64'(busy_o), 0);
    chk("R1", "reset done", 64'(done_o), 0);
    chk("R1", "reset valid/err", 64'({valid_o, err_o}), 0);
    chk("R3", "reset count", 64'(remaining_o), 0);
    chk("R5", "reset write", 64'(mem_we_o), 0);
  endtask

  task automatic t_short();
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    start_i = 1'b1; len_i = 16'd15; no_store_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4", "refuse done", 64'(done_o), 1);
    chk("R4", "refuse err", 64'(err_o), 1);
    chk("R4", "refuse busy", 64'(busy_o), 0);
    @(negedge clk);
    chk("R4", "refuse writes", 64'(wr_cnt - w0), 0);
  endtask

  task automatic t_good();
    fill_aa(); build(24, 64, 1'b1);
    run_load(200, 1'b0, -1, 8);
    chk("R1", "good valid", 64'(valid_o), 1);
    chk("R1", "good err", 64'(err_o), 0);
    chk("R2", "header word 0", 64'(header_o[31:0]), 64'({img[3], img[2], img[1], img[0]}));
    chk("R2", "header word 3", 64'(header_o[127:96]), 64'({img[15], img[14], img[13], img[12]}));
    check_mem("R5/R6/R7", 24, 64, 1'b1, 1'b1);
  endtask

  task automatic t_odd_end();
    fill_aa(); build(22, 48, 1'b1);
    run_load(22, 1'b0, -1, 6);
    chk("R1", "odd-end valid", 64'(valid_o), 1);
    check_mem("R7", 22, 48, 1'b1, 1'b1);
  endtask

  task automatic t_bad_sum();
    int w0;
    fill_aa(); build(24, 64, 1'b0); w0 = wr_cnt;
    run_load(24, 1'b0, -1, 8);
    chk("R1", "bad-sum err", 64'(err_o), 1);
    chk("R1", "bad-sum valid", 64'(valid_o), 0);
    repeat (4) @(negedge clk);
    chk("R8", "bad-sum write count", 64'(wr_cnt - w0), 24);
    check_mem("R8", 24, 64, 1'b1, 1'b0);
  endtask

  task automatic t_xfer_err();
    fill_aa(); build(24, 64, 1'b1);
    run_load(24, 1'b0, 20, 8);
    chk("R10", "transfer error flags image", 64'(err_o), 1);
    repeat (4) @(negedge clk);
    check_mem("R10", 24, 64, 1'b1, 1'b0);
  endtask

  task automatic t_no_store();
    int w0;
    fill_aa(); build(24, 64, 1'b1); w0 = wr_cnt;
    run_load(24, 1'b1, -1, 8);
    chk("R9", "no-store valid", 64'(valid_o), 1);
    chk("R9", "no-store writes", 64'(wr_cnt - w0), 0);
    chk("R9", "no-store header word 2", 64'(header_o[95:64]), 64'({img[11], img[10], img[9], img[8]}));
    check_mem("R9", 24, 64, 1'b0, 1'b0);
  endtask

  task automatic t_short_field();
    fill_aa(); build(12, 32, 1'b1);
    run_load(100, 1'b0, -1, -1);
    chk("R3", "short field valid", 64'(valid_o), 1);
    check_mem("R3/R7", 12, 32, 1'b1, 1'b1);
  endtask

  task automatic t_idle_bytes();
    int w0;
    logic v0;
    w0 = wr_cnt; v0 = valid_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      byte_valid_i = 1'b1; byte_i = 8'(i + 1);
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
    chk("R11", "idle bytes busy", 64'(busy_o), 0);
    chk("R11", "idle bytes count", 64'(remaining_o), 0);
    chk("R11", "idle bytes writes", 64'(wr_cnt - w0), 0);
    chk("R11", "idle bytes status", 64'(valid_o), 64'(v0));
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; len_i = '0; no_store_i = 1'b0;
    byte_valid_i = 1'b0; byte_i = '0; xfer_err_i = 1'b0;
    fill_aa();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_short();
    t_good();
    t_idle_bytes();
    t_odd_end();
    t_bad_sum();
    t_xfer_err();
    t_no_store();
    t_short_field();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule